// File: doc/BRIEF.md
# Password Block Lock Controller

This unit decides who may touch each block of a block-organised nonvolatile memory. Every block carries a password of one, two or three 32-bit words, supplied with a length code and a protection code on configuration inputs loaded from the memory itself. A block that has a valid password comes out of reset locked. Software unlocks it by selecting the block and then writing the password into a single unlock register, one word per write. The same register relocks the block when it receives a word of all ones.

Block 0 is the master. While block 0 has a password and is locked, the block-select register stays at 0, and every access to any other block is refused. A combinational access-check port takes a block index, a read/write flag and a requester class. It answers grant or deny from four inputs together: the block's protection code, whether the block has a password, the block's lock state, and the block's supervisor-only flag.

Top module: `pwlock_ctrl`

## Requirements
- R1: After reset the select register reads 0, and every block with a valid password reads locked. Reading register address 1 returns bit 0 = 1 when the selected block is locked, and 0 when it is unlocked or has no password.
- R2: The length code of a block gives its password length: 0 means no password, and 1 to 3 give that many 32-bit words. A password whose used words all equal 0xFFFFFFFF counts as no password, so that block is never locked.
- R3: Writes to address 1 of words other than 0xFFFFFFFF are compared with the selected block's password, first word first. The write that completes a full in-order match unlocks the block on the next clock.
- R4: A word that does not match restarts the sequence at the first word, and the block stays locked.
- R5: Writing 0xFFFFFFFF to address 1 relocks the selected block if it has a password. With block 0 selected, that write relocks every block that has a password. Either way the sequence restarts.
- R6: A write to address 0 loads the block select, but only when the value is below the block count. The write is ignored while block 0 has a password and is locked.
- R7: While block 0 has a password and is locked, every access to a block other than 0 is denied.
- R8: Protection code 0 grants every access to a block without a password. For a block with a password it grants reads always and grants writes only while the block is unlocked.
- R9: Protection code 1 grants reads and writes to a block with a password only while it is unlocked. A block without a password is treated as under code 0.
- R10: Protection code 2 never grants a write. Reads are granted always for a block without a password, and only while unlocked for a block with one.
- R11: Protection code 3 denies every access.
- R12: When a block's supervisor-only flag is set, only class 0 (supervisor) can be granted. Class 1 (user), class 2 (DMA) and class 3 (debug) are denied.
- R13: An accepted write to the select register restarts the unlock sequence. Words matched before the write do not count afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 is block select, 1 is unlock |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cfg_pw_len | input | NUM_BLOCKS x 2 | Password length code for each block |
| cfg_pw_word | input | NUM_BLOCKS x 3 x 32 | Password words for each block, word 0 entered first |
| cfg_prot | input | NUM_BLOCKS x 2 | Protection code for each block |
| cfg_sup_only | input | NUM_BLOCKS | Supervisor-only flag for each block |
| acc_blk | input | clog2(NUM_BLOCKS) | Block index of the access under check |
| acc_wr | input | 1 | 1 for a write access, 0 for a read |
| acc_cls | input | 2 | Requester class: 0 supervisor, 1 user, 2 DMA, 3 debug |
| acc_grant | output | 1 | 1 when the access is permitted |

## Verification
The following properties are checked on every cycle:
- The select register holds while the master is locked.
- A relock word leaves the selected block locked.
- Lock state never moves without an unlock-register write.
- The grant is never given across a locked master, to a non-supervisor on a supervisor-only block, for a write under code 2, or under code 3.

Only the bench scenarios can show the following:
- The in-order word comparison, including restart after a mismatch and restart after a change of select.
- Unlock on exactly the last matching word.
- Module-wide relock from block 0.
- Treatment of an all-ones password as no password.
- The positive grants of codes 0 to 2 against a model of lock state.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;

    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = 3;
    localparam int LEN_W     = 2;

    typedef enum logic [1:0] {
        REQ_SUP   = 2'd0,
        REQ_USER  = 2'd1,
        REQ_DMA   = 2'd2,
        REQ_DEBUG = 2'd3
    } req_class_e;

    typedef enum logic [1:0] {
        PROT_WR_LOCKED = 2'd0,
        PROT_RW_LOCKED = 2'd1,
        PROT_READ_ONLY = 2'd2,
        PROT_DENY_ALL  = 2'd3
    } prot_e;

    // Permission from protection code, password presence and lock state.
    function automatic logic perm_ok(prot_e code, logic has_pw, logic unlocked, logic is_wr);
        logic ok;
        unique case (code)
            PROT_WR_LOCKED: ok = has_pw ? (is_wr ? unlocked : 1'b1) : 1'b1;
            PROT_RW_LOCKED: ok = has_pw ? unlocked : 1'b1;
            PROT_READ_ONLY: ok = has_pw ? (!is_wr && unlocked) : !is_wr;
            default:        ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pwlock_pwcheck.sv
module pwlock_pwcheck
    import pwlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 4
) (
    input  logic [NUM_BLOCKS-1:0][LEN_W-1:0]                 cfg_pw_len,
    input  logic [NUM_BLOCKS-1:0][MAX_WORDS-1:0][WORD_W-1:0] cfg_pw_word,
    output logic [NUM_BLOCKS-1:0]                            has_pw
);

    // A password exists when at least one used word is not all ones.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        always_comb begin
            has_pw[b] = 1'b0;
            for (int w = 0; w < MAX_WORDS; w++) begin
                if ((w < int'(cfg_pw_len[b])) && (cfg_pw_word[b][w] != '1)) begin
                    has_pw[b] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwlock_state.sv
module pwlock_state
    import pwlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            wr_sel,
    input  logic                                            wr_unlock,
    input  logic [WORD_W-1:0]                               wdata,
    input  logic [NUM_BLOCKS-1:0]                           has_pw,
    input  logic [NUM_BLOCKS-1:0][LEN_W-1:0]                cfg_pw_len,
    input  logic [NUM_BLOCKS-1:0][MAX_WORDS-1:0][WORD_W-1:0] cfg_pw_word,
    output logic [BLK_W-1:0]                                sel_q,
    output logic [NUM_BLOCKS-1:0]                           lock_eff,
    output logic                                            master_locked
);

    typedef struct packed {
        logic [BLK_W-1:0]      sel;
        logic [NUM_BLOCKS-1:0] lock;
        logic [LEN_W-1:0]      idx;
    } state_t;

    state_t st_d, st_q;

    logic              cur_pw;
    logic [LEN_W-1:0]  cur_len;
    logic [WORD_W-1:0] exp_word;

    always_comb begin
        cur_pw   = has_pw[st_q.sel];
        cur_len  = cfg_pw_len[st_q.sel];
        exp_word = (st_q.idx < LEN_W'(MAX_WORDS)) ? cfg_pw_word[st_q.sel][st_q.idx] : '0;
    end

    assign master_locked = has_pw[0] & st_q.lock[0];

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            if (!master_locked && (wdata < WORD_W'(NUM_BLOCKS))) begin
                st_d.sel = wdata[BLK_W-1:0];
                st_d.idx = '0;
            end
        end else if (wr_unlock) begin
            if (wdata == '1) begin
                st_d.idx = '0;
                if (st_q.sel == '0) begin
                    st_d.lock = st_q.lock | has_pw;
                end else begin
                    st_d.lock[st_q.sel] = st_q.lock[st_q.sel] | cur_pw;
                end
            end else if (cur_pw) begin
                if (wdata == exp_word) begin
                    if ((st_q.idx + LEN_W'(1)) == cur_len) begin
                        st_d.lock[st_q.sel] = 1'b0;
                        st_d.idx            = '0;
                    end else begin
                        st_d.idx = st_q.idx + LEN_W'(1);
                    end
                end else begin
                    st_d.idx = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel  <= '0;
            st_q.lock <= has_pw;
            st_q.idx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q    = st_q.sel;
    assign lock_eff = st_q.lock & has_pw;

endmodule

// File: rtl/pwlock_perm.sv
module pwlock_perm
    import pwlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic [BLK_W-1:0]            acc_blk,
    input  logic                        acc_wr,
    input  logic [1:0]                  acc_cls,
    input  logic [NUM_BLOCKS-1:0][1:0]  cfg_prot,
    input  logic [NUM_BLOCKS-1:0]       cfg_sup_only,
    input  logic [NUM_BLOCKS-1:0]       has_pw,
    input  logic [NUM_BLOCKS-1:0]       lock_eff,
    input  logic                        master_locked,
    output logic                        acc_grant
);

    logic in_range;
    logic priv_ok;
    logic master_ok;

    always_comb begin
        in_range  = (int'(acc_blk) < NUM_BLOCKS);
        priv_ok   = !cfg_sup_only[acc_blk] || (req_class_e'(acc_cls) == REQ_SUP);
        master_ok = (acc_blk == '0) || !master_locked;
        acc_grant = in_range && priv_ok && master_ok &&
                    perm_ok(prot_e'(cfg_prot[acc_blk]), has_pw[acc_blk],
                            !lock_eff[acc_blk], acc_wr);
    end

endmodule

// File: rtl/pwlock_ctrl.sv
module pwlock_ctrl
    import pwlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             bus_wr,
    input  logic                                             bus_addr,
    input  logic [31:0]                                      bus_wdata,
    output logic [31:0]                                      bus_rdata,
    input  logic [NUM_BLOCKS-1:0][1:0]                       cfg_pw_len,
    input  logic [NUM_BLOCKS-1:0][2:0][31:0]                 cfg_pw_word,
    input  logic [NUM_BLOCKS-1:0][1:0]                       cfg_prot,
    input  logic [NUM_BLOCKS-1:0]                            cfg_sup_only,
    input  logic [BLK_W-1:0]                                 acc_blk,
    input  logic                                             acc_wr,
    input  logic [1:0]                                       acc_cls,
    output logic                                             acc_grant
);

    logic [NUM_BLOCKS-1:0] has_pw;
    logic [NUM_BLOCKS-1:0] lock_eff;
    logic [BLK_W-1:0]      sel_q;
    logic                  master_locked;

    pwlock_pwcheck #(.NUM_BLOCKS(NUM_BLOCKS)) u_pwcheck (
        .cfg_pw_len  (cfg_pw_len),
        .cfg_pw_word (cfg_pw_word),
        .has_pw      (has_pw)
    );

    pwlock_state #(.NUM_BLOCKS(NUM_BLOCKS)) u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_sel        (bus_wr && !bus_addr),
        .wr_unlock     (bus_wr && bus_addr),
        .wdata         (bus_wdata),
        .has_pw        (has_pw),
        .cfg_pw_len    (cfg_pw_len),
        .cfg_pw_word   (cfg_pw_word),
        .sel_q         (sel_q),
        .lock_eff      (lock_eff),
        .master_locked (master_locked)
    );

    pwlock_perm #(.NUM_BLOCKS(NUM_BLOCKS)) u_perm (
        .acc_blk       (acc_blk),
        .acc_wr        (acc_wr),
        .acc_cls       (acc_cls),
        .cfg_prot      (cfg_prot),
        .cfg_sup_only  (cfg_sup_only),
        .has_pw        (has_pw),
        .lock_eff      (lock_eff),
        .master_locked (master_locked),
        .acc_grant     (acc_grant)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) begin
            bus_rdata[0] = lock_eff[sel_q];
        end else begin
            bus_rdata[BLK_W-1:0] = sel_q;
        end
    end

endmodule

// File: rtl/pwlock_ctrl_chk.sv
module pwlock_ctrl_chk #(
    parameter int NUM_BLOCKS = 4,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic                       bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [BLK_W-1:0]           acc_blk,
    input logic                       acc_wr,
    input logic [1:0]                 acc_cls,
    input logic [NUM_BLOCKS-1:0][1:0] cfg_prot,
    input logic [NUM_BLOCKS-1:0]      cfg_sup_only,
    input logic                       acc_grant,
    input logic [BLK_W-1:0]           sel_q,
    input logic [NUM_BLOCKS-1:0]      lock_eff,
    input logic [NUM_BLOCKS-1:0]      has_pw,
    input logic                       master_locked
);

    logic blk_ok;
    assign blk_ok = (int'(acc_blk) < NUM_BLOCKS);

    p_sel_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        master_locked |=> (sel_q == $past(sel_q)));

    p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && (bus_wdata == 32'hFFFF_FFFF))
        |=> (lock_eff[$past(sel_q)] == has_pw[$past(sel_q)]));

    p_lock_moves_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr) |=> $stable(lock_eff));

    p_master_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_locked && (acc_blk != '0)) |-> !acc_grant);

    p_sup_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ok && cfg_sup_only[acc_blk] && (acc_cls != 2'd0)) |-> !acc_grant);

    p_ro_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ok && (cfg_prot[acc_blk] == 2'd2) && acc_wr) |-> !acc_grant);

    p_deny_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ok && (cfg_prot[acc_blk] == 2'd3)) |-> !acc_grant);

endmodule

bind pwlock_ctrl pwlock_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .acc_blk       (acc_blk),
    .acc_wr        (acc_wr),
    .acc_cls       (acc_cls),
    .cfg_prot      (cfg_prot),
    .cfg_sup_only  (cfg_sup_only),
    .acc_grant     (acc_grant),
    .sel_q         (sel_q),
    .lock_eff      (lock_eff),
    .has_pw        (has_pw),
    .master_locked (master_locked)
);

// File: tb/pwlock_ctrl_bench.sv
module pwlock_ctrl_bench;

    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic              bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NB-1:0][1:0]       cfg_pw_len;
    logic [NB-1:0][2:0][31:0] cfg_pw_word;
    logic [NB-1:0][1:0]       cfg_prot;
    logic [NB-1:0]            cfg_sup_only;
    logic [1:0]        acc_blk;
    logic              acc_wr;
    logic [1:0]        acc_cls;
    logic              acc_grant;

    int n_chk  = 0;
    int n_fail = 0;

    logic [1:0]    m_sel;
    logic [1:0]    m_idx;
    logic [NB-1:0] m_lock;
    logic [NB-1:0] m_haspw;

    always #2 clk = ~clk;

    pwlock_ctrl #(.NUM_BLOCKS(NB)) u_pwlock_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_pw_len(cfg_pw_len), .cfg_pw_word(cfg_pw_word),
        .cfg_prot(cfg_prot), .cfg_sup_only(cfg_sup_only),
        .acc_blk(acc_blk), .acc_wr(acc_wr), .acc_cls(acc_cls), .acc_grant(acc_grant)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void calc_haspw();
        for (int b = 0; b < NB; b++) begin
            m_haspw[b] = 1'b0;
            for (int w = 0; w < 3; w++)
                if (w < int'(cfg_pw_len[b]) && cfg_pw_word[b][w] != 32'hFFFF_FFFF)
                    m_haspw[b] = 1'b1;
        end
    endfunction

    function automatic logic exp_grant(int b, logic wr, logic [1:0] cls);
        logic pw, unl, ml;
        pw  = m_haspw[b];
        unl = !(m_lock[b] && pw);
        ml  = m_haspw[0] && m_lock[0];
        if (cfg_sup_only[b] && cls != 2'd0) return 1'b0;
        if (b != 0 && ml) return 1'b0;
        case (cfg_prot[b])
            2'd0: return (pw && wr) ? unl : 1'b1;
            2'd1: return pw ? unl : 1'b1;
            2'd2: return wr ? 1'b0 : (pw ? unl : 1'b1);
            default: return 1'b0;
        endcase
    endfunction

    function automatic void model_write(logic a, logic [31:0] d);
        if (!a) begin
            if (!(m_haspw[0] && m_lock[0]) && d < NB) begin
                m_sel = d[1:0];
                m_idx = 2'd0;
            end
        end else if (d == 32'hFFFF_FFFF) begin
            m_idx = 2'd0;
            if (m_sel == 2'd0) m_lock = m_lock | m_haspw;
            else m_lock[m_sel] = m_lock[m_sel] | m_haspw[m_sel];
        end else if (m_haspw[m_sel]) begin
            if (d == cfg_pw_word[m_sel][m_idx]) begin
                if (m_idx + 2'd1 == cfg_pw_len[m_sel]) begin
                    m_lock[m_sel] = 1'b0;
                    m_idx = 2'd0;
                end else m_idx = m_idx + 2'd1;
            end else m_idx = 2'd0;
        end
    endfunction

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        #1;
    endtask

    task automatic rd(logic a, string tag, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic acc(int b, logic w, logic [1:0] c, string tag);
        acc_blk = b[1:0]; acc_wr = w; acc_cls = c;
        #1;
        check(tag, {31'd0, acc_grant}, {31'd0, exp_grant(b, w, c)});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        calc_haspw();
        m_sel = 2'd0; m_idx = 2'd0; m_lock = m_haspw;
        #1;
    endtask

    task automatic rd_status(string tag);
        rd(1'b0, tag, {30'd0, m_sel});
        rd(1'b1, tag, {31'd0, m_lock[m_sel] & m_haspw[m_sel]});
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            int r;
            r = $urandom % 10;
            if (r < 5) wr(1'b1, m_haspw[m_sel] ? cfg_pw_word[m_sel][m_idx] : $urandom);
            else if (r < 6) wr(1'b1, 32'hFFFF_FFFF);
            else if (r < 8) wr(1'b0, $urandom % 5);
            else wr(1'b1, $urandom);
            rd_status("R3 random status");
            for (int k = 0; k < 3; k++) begin
                int b;
                cfg_prot     = $urandom;
                cfg_sup_only = (($urandom % 4) == 0) ? NB'($urandom) : '0;
                b = $urandom % NB;
                acc(b, 1'($urandom), 2'($urandom),
                    cfg_prot[b] == 2'd0 ? "R8 random" : cfg_prot[b] == 2'd1 ? "R9 random" :
                    cfg_prot[b] == 2'd2 ? "R10 random" : "R11 random");
            end
        end
        cfg_sup_only = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
        acc_blk = '0; acc_wr = 1'b0; acc_cls = 2'd0;
        cfg_prot = '0; cfg_sup_only = '0;
        cfg_pw_len  = {2'd0, 2'd3, 2'd1, 2'd2};
        cfg_pw_word = '0;
        cfg_pw_word[0] = {32'h0, 32'hA1A1_0002, 32'hA0A0_0001};
        cfg_pw_word[1] = {32'h0, 32'h0, 32'hB0B0_1111};
        cfg_pw_word[2] = {32'hC2C2_0003, 32'hC1C1_0002, 32'hC0C0_0001};
        do_reset();

        // Reset state
        rd(1'b0, "R1 select after reset", 32'd0);
        rd(1'b1, "R1 block0 locked after reset", 32'd1);
        acc(3, 1'b0, 2'd0, "R7 other block denied while master locked");
        acc(0, 1'b0, 2'd0, "R8 read of locked block granted");
        acc(0, 1'b1, 2'd0, "R8 write of locked block denied");
        cfg_prot[0] = 2'd1;
        acc(0, 1'b0, 2'd0, "R9 read of locked block denied");
        cfg_prot[0] = 2'd0;

        wr(1'b0, 32'd2);
        rd(1'b0, "R6 select held while master locked", 32'd0);

        wr(1'b1, 32'hA0A0_0001); wr(1'b1, 32'h1234_5678); wr(1'b1, 32'hA1A1_0002);
        rd(1'b1, "R4 mismatch keeps block locked", 32'd1);
        wr(1'b1, 32'hA0A0_0001);
        rd(1'b1, "R3 partial match still locked", 32'd1);
        wr(1'b1, 32'hA1A1_0002);
        rd(1'b1, "R3 full match unlocks", 32'd0);
        acc(0, 1'b1, 2'd0, "R8 write granted when unlocked");

        wr(1'b0, 32'd2);
        rd(1'b0, "R6 select accepted when master unlocked", 32'd2);
        rd(1'b1, "R1 block2 locked after reset", 32'd1);
        wr(1'b1, 32'hC0C0_0001); wr(1'b1, 32'hC1C1_0002);
        wr(1'b0, 32'd1); wr(1'b0, 32'd2);
        wr(1'b1, 32'hC2C2_0003);
        rd(1'b1, "R13 select write restarts sequence", 32'd1);
        wr(1'b1, 32'hC0C0_0001); wr(1'b1, 32'hC1C1_0002); wr(1'b1, 32'hC2C2_0003);
        rd(1'b1, "R3 three-word unlock", 32'd0);
        wr(1'b0, 32'd3);
        rd(1'b1, "R1 block without password not locked", 32'd0);
        wr(1'b0, 32'd7);
        rd(1'b0, "R6 out-of-range select ignored", 32'd3);

        wr(1'b0, 32'd1);
        wr(1'b1, 32'hB0B0_1111);
        rd(1'b1, "R3 one-word unlock", 32'd0);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, "R5 relock selected block", 32'd1);
        wr(1'b0, 32'd0);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, "R5 relock block0", 32'd1);
        acc(2, 1'b0, 2'd0, "R7 denied after module relock");
        wr(1'b0, 32'd2);
        rd(1'b0, "R6 select held after module relock", 32'd0);

        random_run(400);

        // Second configuration: no master password, all-ones password on block 3
        cfg_pw_len  = {2'd2, 2'd1, 2'd0, 2'd0};
        cfg_pw_word = '0;
        cfg_pw_word[2] = {32'h0, 32'h0, 32'h5555_AAAA};
        cfg_pw_word[3] = {32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
        cfg_prot = '0;
        do_reset();
        wr(1'b0, 32'd3);
        rd(1'b0, "R6 select free without master password", 32'd3);
        rd(1'b1, "R2 all-ones password counts as none", 32'd0);
        cfg_prot[3] = 2'd2;
        acc(3, 1'b0, 2'd1, "R10 read-only block read granted");
        acc(3, 1'b1, 2'd0, "R10 read-only block write denied");
        cfg_prot[3] = 2'd1;
        acc(3, 1'b1, 2'd1, "R9 no password treated as code 0");
        cfg_prot[3] = 2'd3;
        acc(3, 1'b0, 2'd0, "R11 code 3 denies read");
        cfg_prot[3] = 2'd0;
        cfg_sup_only[3] = 1'b1;
        acc(3, 1'b0, 2'd0, "R12 supervisor granted");
        acc(3, 1'b0, 2'd1, "R12 user denied");
        acc(3, 1'b0, 2'd2, "R12 DMA denied");
        acc(3, 1'b1, 2'd3, "R12 debug denied");
        cfg_sup_only = '0;
        wr(1'b0, 32'd2);
        cfg_prot[2] = 2'd2;
        acc(2, 1'b0, 2'd0, "R10 locked read denied");
        wr(1'b1, 32'h5555_AAAA);
        acc(2, 1'b0, 2'd0, "R10 unlocked read granted");
        acc(2, 1'b1, 2'd0, "R10 unlocked write denied");

        random_run(400);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule